// File: doc/BRIEF.md
# Output-Driver Calibration Mode Controller

This block sits on the memory-device side of a DDR2-style interface. It watches writes to the extended mode register and decodes a three-bit calibration field to choose how the output drivers behave. It keeps one of five states: idle (calibration off), force-high, force-low, step-adjust, or load-default.

In the two force states the block drives fixed levels onto every DQ lane and both strobe polarities, and it raises a pad output-enable. These fixed levels let the controller measure the pull-up or pull-down driver. In the adjust state it flags that later burst codes should step the impedance counters. A default request sends a one-cycle load pulse to those counters. When reduced drive strength is selected, the same request instead raises a one-cycle not-applicable flag.

A field value of 000 only closes calibration. It leaves any calibrated or default impedance in place. Reserved field values change nothing and report an illegal-code pulse.

Top module: `ocd_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `mode_o` is 0 (idle). `drv_oe_o`, `adj_active_o`, `dflt_load_o`, `dflt_na_o` and `bad_code_o` are all 0.
- R2: A write with field 001 gives `mode_o` = 1 from the next clock edge. `drv_oe_o` = 1, every `dq_o` bit = 1, every `dqs_o` bit = 1 and every `dqs_n_o` bit = 0.
- R3: A write with field 010 gives `mode_o` = 2 from the next edge. `drv_oe_o` = 1, every `dq_o` bit = 0, every `dqs_o` bit = 0 and every `dqs_n_o` bit = 1.
- R4: A write with field 100 gives `mode_o` = 3 and `adj_active_o` = 1 from the next edge. In this state `drv_oe_o` = 0 and the pad outputs are released to 0.
- R5: A write with field 000 gives `mode_o` = 0 from the next edge, with `drv_oe_o` = 0 and `adj_active_o` = 0. It raises neither `dflt_load_o` nor `dflt_na_o`.
- R6: A write with field 111 while `reduced_str_i` = 0 gives `mode_o` = 4. It also raises `dflt_load_o` for exactly the cycle after the write, and `dflt_na_o` stays 0.
- R7: A write with field 111 while `reduced_str_i` = 1 gives `mode_o` = 4. It raises `dflt_na_o` for exactly the cycle after the write, and `dflt_load_o` stays 0.
- R8: A write with a reserved field (011, 101 or 110) leaves `mode_o` and the pad outputs unchanged. It raises `bad_code_o` for exactly the cycle after the write.
- R9: While `emr_wr_i` = 0, `mode_o` holds its value whatever `emr_field_i` carries, and all three pulse outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| emr_wr_i | input | 1 | Extended mode register write strobe |
| emr_field_i | input | 3 | Calibration field of the written value |
| reduced_str_i | input | 1 | Reduced drive strength is selected |
| dq_o | output | DQ_W | Forced DQ levels |
| dqs_o | output | DQS_W | Forced true strobe levels |
| dqs_n_o | output | DQS_W | Forced complementary strobe levels |
| drv_oe_o | output | 1 | Pad output-enable for the force states |
| adj_active_o | output | 1 | Adjust state is active |
| dflt_load_o | output | 1 | One-cycle default load to the step counters |
| dflt_na_o | output | 1 | One-cycle flag: default not applicable |
| bad_code_o | output | 1 | One-cycle flag: reserved field written |
| mode_o | output | 3 | Current state: 0 idle, 1 high, 2 low, 3 adjust, 4 default |

## Verification
Each legal field value is written from several different starting states. This shows that each code sets its own state rather than a fixed next state. Reserved values are written while forcing low, while adjusting and while idle, which shows that the state is kept in each case. The default code is written with both strength settings so the load and not-applicable pulses can be told apart. Idle cycles with non-zero field values show that the strobe gates decoding, and a random stretch mixes all codes back to back.

// File: rtl/ocd_pkg.sv
package ocd_pkg;
  typedef enum logic [2:0] {
    OCD_EXIT   = 3'd0,
    OCD_DRV_HI = 3'd1,
    OCD_DRV_LO = 3'd2,
    OCD_ADJ    = 3'd3,
    OCD_DFLT   = 3'd4
  } ocd_mode_e;

  localparam logic [2:0] FLD_EXIT   = 3'b000;
  localparam logic [2:0] FLD_DRV_HI = 3'b001;
  localparam logic [2:0] FLD_DRV_LO = 3'b010;
  localparam logic [2:0] FLD_ADJ    = 3'b100;
  localparam logic [2:0] FLD_DFLT   = 3'b111;

  typedef struct packed {
    logic      load;     // legal code: take new mode
    logic      rsvd;     // reserved code written
    logic      dflt;     // default requested
    ocd_mode_e mode;
  } ocd_cmd_t;
endpackage

// File: rtl/ocd_field_dec.sv
module ocd_field_dec
  import ocd_pkg::*;
(
  input  logic       wr_i,
  input  logic [2:0] field_i,
  output ocd_cmd_t   cmd_o
);
  always_comb begin
    cmd_o      = '0;
    cmd_o.mode = OCD_EXIT;
    if (wr_i) begin
      cmd_o.load = 1'b1;
      unique case (field_i)
        FLD_EXIT:   cmd_o.mode = OCD_EXIT;
        FLD_DRV_HI: cmd_o.mode = OCD_DRV_HI;
        FLD_DRV_LO: cmd_o.mode = OCD_DRV_LO;
        FLD_ADJ:    cmd_o.mode = OCD_ADJ;
        FLD_DFLT: begin
          cmd_o.mode = OCD_DFLT;
          cmd_o.dflt = 1'b1;
        end
        default: begin
          cmd_o.load = 1'b0;
          cmd_o.rsvd = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/ocd_mode_reg.sv
module ocd_mode_reg
  import ocd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  ocd_cmd_t  cmd_i,
  input  logic      reduced_i,
  output ocd_mode_e mode_o,
  output logic      load_o,
  output logic      na_o,
  output logic      bad_o
);
  ocd_mode_e mode_q;
  logic      load_q, na_q, bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= OCD_EXIT;
      load_q <= 1'b0;
      na_q   <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      if (cmd_i.load) mode_q <= cmd_i.mode;
      // default only valid at full strength
      load_q <= cmd_i.dflt & ~reduced_i;
      na_q   <= cmd_i.dflt &  reduced_i;
      bad_q  <= cmd_i.rsvd;
    end
  end

  assign mode_o = mode_q;
  assign load_o = load_q;
  assign na_o   = na_q;
  assign bad_o  = bad_q;
endmodule

// File: rtl/ocd_pad_force.sv
module ocd_pad_force
  import ocd_pkg::*;
#(
  parameter int unsigned DQ_W  = 16,
  parameter int unsigned DQS_W = 2
) (
  input  ocd_mode_e          mode_i,
  output logic [DQ_W-1:0]    dq_o,
  output logic [DQS_W-1:0]   dqs_o,
  output logic [DQS_W-1:0]   dqs_n_o,
  output logic               oe_o
);
  logic hi, lo;
  assign hi   = (mode_i == OCD_DRV_HI);
  assign lo   = (mode_i == OCD_DRV_LO);
  assign oe_o = hi | lo;

  for (genvar g = 0; g < DQ_W; g++) begin : g_dq
    assign dq_o[g] = hi;
  end
  for (genvar g = 0; g < DQS_W; g++) begin : g_dqs
    assign dqs_o[g]   = hi;
    assign dqs_n_o[g] = lo;
  end
endmodule

// File: rtl/ocd_mode_ctrl.sv
module ocd_mode_ctrl
  import ocd_pkg::*;
#(
  parameter int unsigned DQ_W  = 16,
  parameter int unsigned DQS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             emr_wr_i,
  input  logic [2:0]       emr_field_i,
  input  logic             reduced_str_i,
  output logic [DQ_W-1:0]  dq_o,
  output logic [DQS_W-1:0] dqs_o,
  output logic [DQS_W-1:0] dqs_n_o,
  output logic             drv_oe_o,
  output logic             adj_active_o,
  output logic             dflt_load_o,
  output logic             dflt_na_o,
  output logic             bad_code_o,
  output logic [2:0]       mode_o
);
  ocd_cmd_t  cmd;
  ocd_mode_e mode;

  ocd_field_dec u_dec (
    .wr_i    (emr_wr_i),
    .field_i (emr_field_i),
    .cmd_o   (cmd)
  );

  ocd_mode_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .reduced_i (reduced_str_i),
    .mode_o    (mode),
    .load_o    (dflt_load_o),
    .na_o      (dflt_na_o),
    .bad_o     (bad_code_o)
  );

  ocd_pad_force #(.DQ_W(DQ_W), .DQS_W(DQS_W)) u_pad (
    .mode_i  (mode),
    .dq_o    (dq_o),
    .dqs_o   (dqs_o),
    .dqs_n_o (dqs_n_o),
    .oe_o    (drv_oe_o)
  );

  assign adj_active_o = (mode == OCD_ADJ);
  assign mode_o       = mode;
endmodule

// File: rtl/ocd_mode_chk.sv
module ocd_mode_chk #(
  parameter int unsigned DQ_W  = 16,
  parameter int unsigned DQS_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             emr_wr_i,
  input logic [2:0]       emr_field_i,
  input logic             reduced_str_i,
  input logic [DQ_W-1:0]  dq_o,
  input logic [DQS_W-1:0] dqs_o,
  input logic [DQS_W-1:0] dqs_n_o,
  input logic             drv_oe_o,
  input logic             adj_active_o,
  input logic             dflt_load_o,
  input logic             dflt_na_o,
  input logic             bad_code_o,
  input logic [2:0]       mode_o
);
  logic rsvd_wr;
  assign rsvd_wr = emr_wr_i && (emr_field_i == 3'b011 || emr_field_i == 3'b101 ||
                                emr_field_i == 3'b110);

  AST_HI_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1) |-> (drv_oe_o && (&dq_o) && (&dqs_o) && dqs_n_o == '0)); // R2
  AST_LO_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2) |-> (drv_oe_o && dq_o == '0 && dqs_o == '0 && (&dqs_n_o))); // R3
  AST_ADJ_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_active_o |-> !drv_oe_o); // R4
  AST_EXIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emr_wr_i && emr_field_i == 3'b000) |=> (mode_o == 3'd0 && !dflt_load_o && !dflt_na_o)); // R5
  AST_LOAD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emr_wr_i && emr_field_i == 3'b111 && !reduced_str_i) |=> (dflt_load_o && !dflt_na_o)); // R6
  AST_NA_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emr_wr_i && emr_field_i == 3'b111 && reduced_str_i) |=> (dflt_na_o && !dflt_load_o)); // R7
  AST_RSVD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_wr |=> ($stable(mode_o) && bad_code_o)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emr_wr_i |=> ($stable(mode_o) && !dflt_load_o && !dflt_na_o && !bad_code_o)); // R9
endmodule

bind ocd_mode_ctrl ocd_mode_chk #(.DQ_W(DQ_W), .DQS_W(DQS_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .emr_wr_i      (emr_wr_i),
  .emr_field_i   (emr_field_i),
  .reduced_str_i (reduced_str_i),
  .dq_o          (dq_o),
  .dqs_o         (dqs_o),
  .dqs_n_o       (dqs_n_o),
  .drv_oe_o      (drv_oe_o),
  .adj_active_o  (adj_active_o),
  .dflt_load_o   (dflt_load_o),
  .dflt_na_o     (dflt_na_o),
  .bad_code_o    (bad_code_o),
  .mode_o        (mode_o)
);

// File: tb/tb_ocd_mode_ctrl.sv
module tb_ocd_mode_ctrl;
  localparam int DQ_W  = 16;
  localparam int DQS_W = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic emr_wr_i = 1'b0;
  logic [2:0] emr_field_i = 3'b000;
  logic reduced_str_i = 1'b0;
  logic [DQ_W-1:0]  dq_o;
  logic [DQS_W-1:0] dqs_o, dqs_n_o;
  logic drv_oe_o, adj_active_o, dflt_load_o, dflt_na_o, bad_code_o;
  logic [2:0] mode_o;

  always #2.5 clk_i = ~clk_i;

  ocd_mode_ctrl #(.DQ_W(DQ_W), .DQS_W(DQS_W)) dut (.*);

  typedef struct {
    string tag;
    logic [2:0] mode;
    logic oe, adj, load, na, bad;
    logic [DQ_W-1:0] dq;
    logic [DQS_W-1:0] dqs, dqs_n;
  } exp_t;

  exp_t q[$];
  int applied = 0, errors = 0;
  logic [2:0] m_mode = 3'd0;
  bit done = 0;

  function automatic exp_t build(string tag, logic [2:0] md, logic ld, logic na, logic bd);
    exp_t e;
    e.tag = tag; e.mode = md; e.load = ld; e.na = na; e.bad = bd;
    e.oe = (md == 3'd1) || (md == 3'd2);
    e.adj = (md == 3'd3);
    e.dq = (md == 3'd1) ? '1 : '0;
    e.dqs = (md == 3'd1) ? '1 : '0;
    e.dqs_n = (md == 3'd2) ? '1 : '0;
    return e;
  endfunction

  task automatic compare(exp_t e);
    applied++;
    if (mode_o !== e.mode || drv_oe_o !== e.oe || adj_active_o !== e.adj ||
        dflt_load_o !== e.load || dflt_na_o !== e.na || bad_code_o !== e.bad ||
        dq_o !== e.dq || dqs_o !== e.dqs || dqs_n_o !== e.dqs_n) begin
      errors++;
      $display("FAIL %s: act mode=%0d oe=%b adj=%b ld=%b na=%b bad=%b dq=%h dqs=%b dqsn=%b exp mode=%0d oe=%b adj=%b ld=%b na=%b bad=%b dq=%h dqs=%b dqsn=%b",
               e.tag, mode_o, drv_oe_o, adj_active_o, dflt_load_o, dflt_na_o, bad_code_o,
               dq_o, dqs_o, dqs_n_o, e.mode, e.oe, e.adj, e.load, e.na, e.bad,
               e.dq, e.dqs, e.dqs_n);
    end
  endtask

  // driver: one vector per cycle, model predicts state after next edge
  task automatic apply(string tag, logic wr, logic [2:0] fld, logic red);
    logic ld, na, bd;
    @(negedge clk_i);
    emr_wr_i = wr; emr_field_i = fld; reduced_str_i = red;
    ld = 0; na = 0; bd = 0;
    if (wr) begin
      case (fld)
        3'b000: m_mode = 3'd0;
        3'b001: m_mode = 3'd1;
        3'b010: m_mode = 3'd2;
        3'b100: m_mode = 3'd3;
        3'b111: begin m_mode = 3'd4; ld = !red; na = red; end
        default: bd = 1;
      endcase
    end
    q.push_back(build(tag, m_mode, ld, na, bd));
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && q.size() > 0) compare(q.pop_front());
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare(build("R1 in reset", 3'd0, 0, 0, 0));
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    compare(build("R1 after release", 3'd0, 0, 0, 0));

    apply("R2 force high", 1, 3'b001, 0);
    apply("R9 strobe low", 0, 3'b010, 0);
    apply("R3 force low", 1, 3'b010, 0);
    apply("R8 rsvd 011 in low", 1, 3'b011, 0);
    apply("R9 hold low", 0, 3'b000, 0);
    apply("R4 adjust", 1, 3'b100, 0);
    apply("R8 rsvd 101 in adjust", 1, 3'b101, 1);
    apply("R6 default full", 1, 3'b111, 0);
    apply("R6 pulse ends", 0, 3'b111, 0);
    apply("R7 default reduced", 1, 3'b111, 1);
    apply("R5 exit", 1, 3'b000, 0);
    apply("R8 rsvd 110 idle", 1, 3'b110, 0);
    apply("R2 from idle", 1, 3'b001, 1);
    apply("R6 default back to back", 1, 3'b111, 0);
    apply("R6 second load", 1, 3'b111, 0);
    apply("R3 from default", 1, 3'b010, 0);
    apply("R2 high after low", 1, 3'b001, 0);
    apply("R5 exit from high", 1, 3'b000, 1);
    apply("R9 idle field 001", 0, 3'b001, 0);
    for (int i = 0; i < 60; i++) begin
      logic w;
      logic [2:0] f;
      logic r;
      w = ($urandom_range(0, 3) != 0);
      f = 3'($urandom_range(0, 7));
      r = 1'($urandom_range(0, 1));
      apply("R9 random mix", w, f, r);
    end
    apply("R5 final exit", 1, 3'b000, 0);
    @(negedge clk_i);
    emr_wr_i = 0;
    repeat (2) @(posedge clk_i);
    #2;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule